// File: doc/BRIEF.md
# Clock Source Control Flag Register

This block is a single 8-bit control and status register for the clock section of a microcontroller. Software reads and writes it through a plain register port. Hardware sets some of its bits: the cause of the last reset, an external-stop event, the PLL lock state, and whether the alternate clock is running. From the stored bits the block picks the system clock source and decides whether the crystal oscillator may be stopped.

There are four possible sources: the oscillator divided by 16, the plain oscillator, the PLL, and an alternate clock. The alternate clock wins whenever it is running. Otherwise a cleared divide select forces the divided clock. Otherwise the PLL is used only when it is both selected and locked.

An oscillator-stop request written by software stays hidden until the alternate clock runs. Several hardware events withdraw the PLL selection automatically. Every toggle of the divide select raises a one-cycle interrupt pulse.

Top module: `clk_src_flags`

## Requirements
- R1: Reset is asynchronous and active low. While it is low, the register takes a value that depends on the cause inputs: 0x48 if `rst_wdg` is high, 0x28 if only `rst_sw` is high, and 0x08 if both are low. The watchdog cause wins when both are high.
- R2: `rd_data` shows the register from bit 7 down to bit 0 in this order: external-stop flag, watchdog-reset flag, software-reset flag, oscillator-stop, divide select, alternate-clock status, PLL lock, PLL select.
- R3: A high `ext_stop_evt` sets bit 7 at the next clock edge. A write with bit 7 = 0 clears it, but only when no event occurs in the same cycle. Writing 1 to bit 7 never sets it.
- R4: Writes to bits 6, 5, 2 and 1 are ignored. Bits 6 and 5 keep their reset-time value until the next reset. Bit 1 is the registered `pll_lock` input.
- R5: Writing 1 to bit 4 records a pending stop request and bit 4 still reads 0. Once the alternate clock is running, or in the same cycle it starts, bit 4 reads 1 and `osc_stop` is high.
- R6: Any write with bit 4 = 0 cancels a pending request and clears a set stop. After such a write, starting the alternate clock does not stop the oscillator.
- R7: Each write that changes bit 3 (0 to 1 or 1 to 0) causes `irq` to be high for exactly one cycle, in the cycle after the write edge. A write that leaves bit 3 unchanged causes no pulse.
- R8: Bit 0 is cleared by hardware, overriding any write in the same cycle, in each of these cases: `pll_cfg` = 3'b111; the oscillator is stopped; `wfi` and `wfi_lowpwr` are both high; bit 3 becomes 0; `pll_lock` is low.
- R9: `src_sel` is encoded as 0 = oscillator/16, 1 = oscillator, 2 = PLL, 3 = alternate clock. It is 3 while bit 2 is set. Otherwise it is 0 while bit 3 is 0. Otherwise it is 2 when bits 0 and 1 are both set, and 1 in all other cases.
- R10: Bit 2 is the value of `alt_req` AND `alt_present` registered at the last clock edge. A request without a clock present does not select the alternate clock.
- R11: When the alternate clock stops running, bit 4 and `osc_stop` clear in the same cycle. The oscillator is never held stopped without the alternate clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_wdg | input | 1 | Reset cause is a watchdog, sampled during reset |
| rst_sw | input | 1 | Reset cause is software, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| ext_stop_evt | input | 1 | External stop condition |
| pll_lock | input | 1 | PLL locked |
| pll_cfg | input | 3 | PLL configuration code |
| alt_req | input | 1 | Alternate clock requested |
| alt_present | input | 1 | Clock present on the alternate input |
| wfi | input | 1 | Wait-for-interrupt executing |
| wfi_lowpwr | input | 1 | Low-power mode during wait-for-interrupt enabled |
| src_sel | output | 2 | Selected system clock source |
| osc_stop | output | 1 | Stop the crystal oscillator |
| irq | output | 1 | One-cycle pulse on a divide-select change |

## Verification
The source selection is swept over every combination of alternate request, alternate presence, PLL lock, divide select and PLL select. This separates the priority of the alternate clock from the divide override, and the divide override from the lock qualification of the PLL.

The oscillator-stop sequences are run three ways: request before the alternate clock starts, request cancelled before it starts, and alternate clock removed while stopped. Together they distinguish a hidden pending request from a visible one.

Each hardware clear of the PLL select is triggered alone. The wait-for-interrupt case is also run without the low-power qualifier, which shows that only the full condition clears the bit.

// File: rtl/clk_src_flags.sv
module clk_src_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_wdg,
  input  logic       rst_sw,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_stop_evt,
  input  logic       pll_lock,
  input  logic [2:0] pll_cfg,
  input  logic       alt_req,
  input  logic       alt_present,
  input  logic       wfi,
  input  logic       wfi_lowpwr,
  output logic [1:0] src_sel,
  output logic       osc_stop,
  output logic       irq
);
  localparam logic [1:0] SRC_DIV16 = 2'd0;
  localparam logic [1:0] SRC_OSC   = 2'd1;
  localparam logic [1:0] SRC_PLL   = 2'd2;
  localparam logic [1:0] SRC_ALT   = 2'd3;

  logic ext_stop, wdg_f, sw_f, xt_stop, xt_pend, div_sel, div_q;
  logic alt_st, lock_q, pll_sel, live;
  logic alt_n, div_n, xt_n, pend_n, pll_clr;

  assign alt_n = alt_req & alt_present;
  assign div_n = wr_en ? wr_data[3] : div_sel;

  always_comb begin
    xt_n   = xt_stop;
    pend_n = xt_pend;
    if (wr_en) begin
      if (wr_data[4]) pend_n = 1'b1;
      else begin
        pend_n = 1'b0;
        xt_n   = 1'b0;
      end
    end
    if (!alt_n) xt_n = 1'b0;
    else if (pend_n) begin
      xt_n   = 1'b1;
      pend_n = 1'b0;
    end
  end

  assign pll_clr = (pll_cfg == 3'b111) | xt_n | (wfi & wfi_lowpwr) | !div_n | !pll_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_stop <= 1'b0;
      wdg_f    <= rst_wdg;
      sw_f     <= rst_sw & ~rst_wdg;
      xt_stop  <= 1'b0;
      xt_pend  <= 1'b0;
      div_sel  <= 1'b1;
      div_q    <= 1'b1;
      alt_st   <= 1'b0;
      lock_q   <= 1'b0;
      pll_sel  <= 1'b0;
      live     <= 1'b0;
    end else begin
      ext_stop <= ext_stop_evt | (ext_stop & ~(wr_en & ~wr_data[7]));
      xt_stop  <= xt_n;
      xt_pend  <= pend_n;
      div_sel  <= div_n;
      div_q    <= div_sel;
      alt_st   <= alt_n;
      lock_q   <= pll_lock;
      pll_sel  <= ~pll_clr & (wr_en ? wr_data[0] : pll_sel);
      live     <= 1'b1;
    end
  end

  assign rd_data  = {ext_stop, wdg_f, sw_f, xt_stop, div_sel, alt_st, lock_q, pll_sel};
  assign osc_stop = xt_stop;
  assign irq      = div_sel ^ div_q;

  always_comb begin
    if (alt_st)                  src_sel = SRC_ALT;
    else if (!div_sel)           src_sel = SRC_DIV16;
    else if (pll_sel && lock_q)  src_sel = SRC_PLL;
    else                         src_sel = SRC_OSC;
  end

  AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(ext_stop_evt) |-> rd_data[7]); // R3
  AST_RO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $stable(rd_data[6:5])); // R4
  AST_STOP_NEEDS_ALT: assert property (@(posedge clk) disable iff (!rst_n || !live)
    osc_stop |-> rd_data[2]); // R11
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (wr_en && !wr_data[4]) |=> !osc_stop); // R6
  AST_IRQ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(wr_en && (wr_data[3] != rd_data[3])) |-> irq); // R7
  AST_PLL_CFG_CLR: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(pll_cfg == 3'b111) |-> !rd_data[0]); // R8
  AST_PLL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (src_sel == SRC_PLL) |-> (rd_data[1] && rd_data[3] && !rd_data[2])); // R9
  AST_ALT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $rose(rd_data[2]) |-> $past(alt_req && alt_present)); // R10
endmodule

// File: tb/sim_clk_src_flags.sv
module sim_clk_src_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_wdg = 1'b0, rst_sw = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic ext_stop_evt = 1'b0, pll_lock = 1'b0, alt_req = 1'b0, alt_present = 1'b0;
  logic wfi = 1'b0, wfi_lowpwr = 1'b0;
  logic [2:0] pll_cfg = 3'd0;
  logic [1:0] src_sel;
  logic osc_stop, irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clk_src_flags u0 (.clk, .rst_n, .rst_wdg, .rst_sw, .wr_en, .wr_data, .rd_data,
    .ext_stop_evt, .pll_lock, .pll_cfg, .alt_req, .alt_present, .wfi, .wfi_lowpwr,
    .src_sel, .osc_stop, .irq);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic w, input logic s);
    rst_wdg = w; rst_sw = s; rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick();
    rst_wdg = 1'b0; rst_sw = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick();
    // R1 reset values by cause
    do_reset(1'b0, 1'b0); chk("R1 por", rd_data, 8'h08);
    chk("R9 reset src", {6'd0, src_sel}, 8'd1);
    chk("R7 reset irq", {7'd0, irq}, 8'd0);
    do_reset(1'b0, 1'b1); chk("R1 sw", rd_data, 8'h28);
    do_reset(1'b1, 1'b1); chk("R1 wdg prio", rd_data, 8'h48);
    do_reset(1'b1, 1'b0); chk("R1 wdg", rd_data, 8'h48);

    // R4 read-only bits ignore writes
    wr(8'h26); chk("R4 ro", rd_data, 8'h40);
    wr(8'h08);

    // R3 external stop flag
    wr(8'h88); chk("R3 write1 no set", {7'd0, rd_data[7]}, 8'd0);
    ext_stop_evt = 1'b1; tick(); ext_stop_evt = 1'b0;
    chk("R3 set", {7'd0, rd_data[7]}, 8'd1);
    wr(8'h88); chk("R3 write1 keeps", {7'd0, rd_data[7]}, 8'd1);
    ext_stop_evt = 1'b1; wr(8'h08); ext_stop_evt = 1'b0;
    chk("R3 event beats clear", {7'd0, rd_data[7]}, 8'd1);
    wr(8'h08); chk("R3 clear", {7'd0, rd_data[7]}, 8'd0);

    // R9 R10 R8 R7 R2 exhaustive source sweep
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      logic ar, ap, lk, d, p, pd, exp_alt, exp_pll;
      logic [1:0] exp_src;
      ar = i[4]; ap = i[3]; lk = i[2]; d = i[1]; p = i[0];
      pd = rd_data[3];
      alt_req = ar; alt_present = ap; pll_lock = lk;
      wr({4'b0000, d, 2'b00, p});
      exp_alt = ar & ap;
      exp_pll = p & d & lk;
      exp_src = exp_alt ? 2'd3 : (!d ? 2'd0 : (exp_pll ? 2'd2 : 2'd1));
      chk("R2 R10 R8 sweep rd", rd_data, {4'b0000, d, exp_alt, lk, exp_pll});
      chk("R9 sweep src", {6'd0, src_sel}, {6'd0, exp_src});
      chk("R7 sweep irq", {7'd0, irq}, {7'd0, d ^ pd});
      tick();
      chk("R7 single pulse", {7'd0, irq}, 8'd0);
    end
    alt_req = 1'b0; alt_present = 1'b0;

    // R8 individual clear causes
    pll_lock = 1'b1; wr(8'h09); tick();
    chk("R8 setup", {6'd0, src_sel}, 8'd2);
    pll_cfg = 3'b111; tick(); pll_cfg = 3'b011;
    chk("R8 cfg111", {7'd0, rd_data[0]}, 8'd0);
    wr(8'h09); chk("R8 cfg other keeps", {7'd0, rd_data[0]}, 8'd1);
    wfi = 1'b1; tick();
    chk("R8 wfi only keeps", {7'd0, rd_data[0]}, 8'd1);
    wfi_lowpwr = 1'b1; tick(); wfi = 1'b0; wfi_lowpwr = 1'b0;
    chk("R8 wfi lowpwr", {7'd0, rd_data[0]}, 8'd0);
    wr(8'h09); pll_lock = 1'b0; tick();
    chk("R8 lock lost", {7'd0, rd_data[0]}, 8'd0);
    chk("R9 lock lost src", {6'd0, src_sel}, 8'd1);
    pll_lock = 1'b1; wr(8'h09); wr(8'h01);
    chk("R8 div zero", rd_data, 8'h02);
    chk("R9 div16 src", {6'd0, src_sel}, 8'd0);

    // R5 R11 R6 oscillator stop sequences
    wr(8'h09);
    wr(8'h19); chk("R5 hidden", {7'd0, rd_data[4]}, 8'd0);
    chk("R5 no stop", {7'd0, osc_stop}, 8'd0);
    alt_req = 1'b1; tick(3);
    chk("R10 no clock present", {7'd0, rd_data[2]}, 8'd0);
    chk("R5 still hidden", {7'd0, osc_stop}, 8'd0);
    alt_present = 1'b1; tick();
    chk("R5 stop visible", rd_data, 8'h1E);
    chk("R5 osc_stop", {7'd0, osc_stop}, 8'd1);
    chk("R9 alt src", {6'd0, src_sel}, 8'd3);
    alt_req = 1'b0; tick();
    chk("R11 stop released", {7'd0, osc_stop}, 8'd0);
    chk("R11 bit4", {7'd0, rd_data[4]}, 8'd0);
    wr(8'h18); wr(8'h08);
    alt_req = 1'b1; tick(3);
    chk("R6 cancel", {7'd0, osc_stop}, 8'd0);
    chk("R6 cancel bit", {7'd0, rd_data[4]}, 8'd0);
    wr(8'h18); chk("R5 direct", {7'd0, osc_stop}, 8'd1);
    wr(8'h08); chk("R6 clear set", {7'd0, osc_stop}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule